// File: doc/BRIEF.md
# Direct-Indexed Address Translation Buffer

This block turns a 64-bit virtual address from the core into a 52-bit physical address. It caches recent translations in a small table. Each slot of the table is chosen directly by low bits of the virtual page number, so only one slot is examined per lookup. When the examined slot is valid and holds the same upper page bits as the request, the stored frame number is put in front of the untouched page offset. The core then sees the answer on the cycle after its request was taken.

When the examined slot does not match, the block passes the virtual page number to an external page-table walker and waits. When the walker returns a frame number, the block writes it into the slot that the request selected and then answers the core. The block handles one request at a time. It takes no new request until the current answer has been taken.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every slot is invalid, `req_ready` is 1 and `rsp_valid` and `walk_valid` are 0. The first lookup to any address, including one that was cached before the reset, is a miss.
- R2: The address fields are as follows. `req_vaddr[11:0]` is the page offset and reaches `rsp_paddr[11:0]` unchanged. `req_vaddr[15:12]` selects the slot. `req_vaddr[47:16]` is the compared tag. `req_vaddr[63:48]` plays no part in the translation.
- R3: A hit occurs when the selected slot is valid and its tag equals the request tag. On a hit, `rsp_valid` rises on the cycle after acceptance with `rsp_paddr = {stored frame, offset}`, and `walk_valid` stays 0.
- R4: A miss raises `walk_valid` on the cycle after acceptance, with `walk_vpn = req_vaddr[47:12]`.
- R5: Only one request is outstanding at a time. `req_ready` is 0 from acceptance until the response is taken. A request offered while the block is busy is neither accepted nor walked.
- R6: The block takes `refill_valid` only while it waits for a refill. It then writes the slot that the request selected and marks it valid. On the next cycle it raises `rsp_valid` with `rsp_paddr = {refill_pfn, offset}`, and a later lookup of the same page hits.
- R7: `refill_valid` asserted while no refill is awaited has no effect: no response appears and no slot changes.
- R8: A request whose slot holds a different tag misses. Its refill replaces the old translation, so the old page then misses.
- R9: `rsp_valid` and `rsp_paddr` hold steady until `rsp_ready`. `req_ready` returns on the cycle after the response is taken.
- R10: `walk_valid` and `walk_vpn` hold steady until `walk_ready`, and `walk_valid` drops on the cycle after the walker accepts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core offers a virtual address |
| req_ready | output | 1 | Block can take a request |
| req_vaddr | input | 64 | Virtual address |
| rsp_valid | output | 1 | Translated address is available |
| rsp_ready | input | 1 | Core takes the response |
| rsp_paddr | output | 52 | Physical address |
| walk_valid | output | 1 | Walk requested for a missing page |
| walk_ready | input | 1 | Walker accepts the walk request |
| walk_vpn | output | 36 | Virtual page number to walk |
| refill_valid | input | 1 | Walker returns a frame number |
| refill_pfn | input | 40 | Returned physical frame number |

## Verification
A slot left valid by mistake or holding a wrong tag shows at the ports on the cycle after acceptance. The response then appears when `walk_valid` was expected, or the other way round. A wrong stored frame shows in the upper bits of `rsp_paddr` in that same cycle. Refills that go to the wrong slot, or that are taken when no walk is pending, show only on a later lookup of the affected page. The bench therefore always revisits pages after conflicts, stray refills and resets. A stuck handshake state shows as `req_ready` failing to return one cycle after `rsp_ready`.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WALK = 2'd1,
      ST_WAIT = 2'd2,
      ST_RESP = 2'd3
   } tlb_state_e;
endpackage

// File: rtl/tlb_addr_split.sv
module tlb_addr_split #(
   parameter int VA_W      = 64,
   parameter int PAGE_BITS = 12,
   parameter int VPN_HI    = 47,
   parameter int IDX_BITS  = 4,
   localparam int VPN_W    = VPN_HI + 1 - PAGE_BITS,
   localparam int TAG_W    = VPN_W - IDX_BITS
) (
   input  logic [VA_W-1:0]      vaddr,
   output logic [PAGE_BITS-1:0] off,
   output logic [VPN_W-1:0]     vpn,
   output logic [IDX_BITS-1:0]  idx,
   output logic [TAG_W-1:0]     tag
);
   assign off = vaddr[PAGE_BITS-1:0];
   assign vpn = vaddr[VPN_HI:PAGE_BITS];
   assign idx = vpn[IDX_BITS-1:0];
   assign tag = vpn[VPN_W-1:IDX_BITS];

   // bits above the page number never take part in translation
   if (VPN_HI < VA_W - 1) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^vaddr[VA_W-1:VPN_HI+1];
   end
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
   parameter int IDX_BITS   = 4,
   parameter int TAG_W      = 32,
   parameter int PFN_W      = 40,
   parameter bit FULL_RESET = 1'b0,
   localparam int DEPTH     = 1 << IDX_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [IDX_BITS-1:0] rd_idx,
   input  logic [TAG_W-1:0]    rd_tag,
   output logic                rd_hit,
   output logic [PFN_W-1:0]    rd_pfn,
   input  logic                wr_en,
   input  logic [IDX_BITS-1:0] wr_idx,
   input  logic [TAG_W-1:0]    wr_tag,
   input  logic [PFN_W-1:0]    wr_pfn
);
   logic [DEPTH-1:0]             vld_all;
   logic [DEPTH-1:0][TAG_W-1:0]  tag_all;
   logic [DEPTH-1:0][PFN_W-1:0]  pfn_all;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic             we;
      logic             vld_r;
      logic [TAG_W-1:0] tag_r;
      logic [PFN_W-1:0] pfn_r;

      assign we = wr_en && (wr_idx == IDX_BITS'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  vld_r <= 1'b0;
         else if (we) vld_r <= 1'b1;
      end

      if (FULL_RESET) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tag_r <= '0;
               pfn_r <= '0;
            end else if (we) begin
               tag_r <= wr_tag;
               pfn_r <= wr_pfn;
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (we) begin
               tag_r <= wr_tag;
               pfn_r <= wr_pfn;
            end
         end
      end

      assign vld_all[i] = vld_r;
      assign tag_all[i] = tag_r;
      assign pfn_all[i] = pfn_r;
   end

   assign rd_hit = vld_all[rd_idx] && (tag_all[rd_idx] == rd_tag);
   assign rd_pfn = pfn_all[rd_idx];
endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
   import tlb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic lookup_hit,
   input  logic walk_ready,
   input  logic refill_valid,
   input  logic rsp_ready,
   output logic req_ready,
   output logic walk_valid,
   output logic rsp_valid,
   output logic take_req,
   output logic take_refill
);
   tlb_state_e state_q, state_d;

   assign req_ready   = (state_q == ST_IDLE);
   assign walk_valid  = (state_q == ST_WALK);
   assign rsp_valid   = (state_q == ST_RESP);
   assign take_req    = req_valid && req_ready;
   assign take_refill = (state_q == ST_WAIT) && refill_valid;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (take_req)    state_d = lookup_hit ? ST_RESP : ST_WALK;
         ST_WALK: if (walk_ready)  state_d = ST_WAIT;
         ST_WAIT: if (take_refill) state_d = ST_RESP;
         ST_RESP: if (rsp_ready)   state_d = ST_IDLE;
         default:                  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
   parameter int VA_W       = 64,
   parameter int PAGE_BITS  = 12,
   parameter int VPN_HI     = 47,
   parameter int IDX_BITS   = 4,
   parameter int PFN_W      = 40,
   parameter bit FULL_RESET = 1'b0,
   localparam int VPN_W     = VPN_HI + 1 - PAGE_BITS,
   localparam int TAG_W     = VPN_W - IDX_BITS,
   localparam int PA_W      = PFN_W + PAGE_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VA_W-1:0]  req_vaddr,
   output logic             rsp_valid,
   input  logic             rsp_ready,
   output logic [PA_W-1:0]  rsp_paddr,
   output logic             walk_valid,
   input  logic             walk_ready,
   output logic [VPN_W-1:0] walk_vpn,
   input  logic             refill_valid,
   input  logic [PFN_W-1:0] refill_pfn
);
   if (VPN_HI >= VA_W) begin : g_bad_hi
      $error("page number top bit lies outside the virtual address");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("index bits leave no tag bits");
   end
   if (IDX_BITS < 1 || IDX_BITS > 10) begin : g_bad_idx
      $error("index width out of supported range");
   end

   logic [PAGE_BITS-1:0] in_off;
   logic [VPN_W-1:0]     in_vpn;
   logic [IDX_BITS-1:0]  in_idx;
   logic [TAG_W-1:0]     in_tag;

   tlb_addr_split #(
      .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .VPN_HI(VPN_HI), .IDX_BITS(IDX_BITS)
   ) u_split (
      .vaddr(req_vaddr), .off(in_off), .vpn(in_vpn), .idx(in_idx), .tag(in_tag)
   );

   logic             take_req, take_refill;
   logic             look_hit;
   logic [PFN_W-1:0] look_pfn;

   logic [PAGE_BITS-1:0] cap_off;
   logic [VPN_W-1:0]     cap_vpn;
   logic [PFN_W-1:0]     out_pfn;

   tlb_entry_array #(
      .IDX_BITS(IDX_BITS), .TAG_W(TAG_W), .PFN_W(PFN_W), .FULL_RESET(FULL_RESET)
   ) u_array (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(in_idx), .rd_tag(in_tag), .rd_hit(look_hit), .rd_pfn(look_pfn),
      .wr_en(take_refill),
      .wr_idx(cap_vpn[IDX_BITS-1:0]), .wr_tag(cap_vpn[VPN_W-1:IDX_BITS]),
      .wr_pfn(refill_pfn)
   );

   tlb_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .lookup_hit(look_hit), .walk_ready(walk_ready),
      .refill_valid(refill_valid), .rsp_ready(rsp_ready),
      .req_ready(req_ready), .walk_valid(walk_valid), .rsp_valid(rsp_valid),
      .take_req(take_req), .take_refill(take_refill)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_off <= '0;
         cap_vpn <= '0;
         out_pfn <= '0;
      end else begin
         if (take_req) begin
            cap_off <= in_off;
            cap_vpn <= in_vpn;
            if (look_hit) out_pfn <= look_pfn;
         end
         if (take_refill) out_pfn <= refill_pfn;
      end
   end

   assign rsp_paddr = {out_pfn, cap_off};
   assign walk_vpn  = cap_vpn;
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
   parameter int VA_W      = 64,
   parameter int PAGE_BITS = 12,
   parameter int VPN_HI    = 47,
   parameter int PFN_W     = 40,
   localparam int VPN_W    = VPN_HI + 1 - PAGE_BITS,
   localparam int PA_W     = PFN_W + PAGE_BITS
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic [VA_W-1:0]  req_vaddr,
   input logic             rsp_valid,
   input logic             rsp_ready,
   input logic [PA_W-1:0]  rsp_paddr,
   input logic             walk_valid,
   input logic             walk_ready,
   input logic [VPN_W-1:0] walk_vpn,
   input logic             refill_valid,
   input logic [PFN_W-1:0] refill_pfn
);
   logic [PAGE_BITS-1:0] c_off;
   logic [VPN_W-1:0]     c_vpn;
   logic                 c_wait;
   logic                 unused_va;

   assign unused_va = ^req_vaddr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_off  <= '0;
         c_vpn  <= '0;
         c_wait <= 1'b0;
      end else begin
         if (req_valid && req_ready) begin
            c_off <= req_vaddr[PAGE_BITS-1:0];
            c_vpn <= req_vaddr[VPN_HI:PAGE_BITS];
         end
         if (walk_valid && walk_ready) c_wait <= 1'b1;
         else if (refill_valid)        c_wait <= 1'b0;
      end
   end

   assert_busy_not_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_valid || rsp_valid || c_wait) |-> !req_ready);

   assert_walk_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_valid && !walk_ready) |=> (walk_valid && $stable(walk_vpn)));

   assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)));

   assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_paddr[PAGE_BITS-1:0] == c_off));

   assert_walk_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
      walk_valid |-> (walk_vpn == c_vpn));

   assert_refill_answer_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (refill_valid && c_wait) |=>
         (rsp_valid && rsp_paddr[PA_W-1:PAGE_BITS] == $past(refill_pfn)));
endmodule

bind tlb_xlate tlb_xlate_chk #(
   .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .VPN_HI(VPN_HI), .PFN_W(PFN_W)
) u_chk (.*);

// File: tb/tlb_xlate_tb.sv
module tlb_xlate_tb;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [63:0] va;
      logic        hit;
      logic [39:0] pfn;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{va:64'h0000_1234_5678_9ABC, hit:1'b0, pfn:40'hAB_CDEF_0123}, // R4 cold miss, slot 9
      '{va:64'h0000_1234_5678_9FFF, hit:1'b1, pfn:40'hAB_CDEF_0123}, // R3 same page
      '{va:64'hFFFF_1234_5678_9000, hit:1'b1, pfn:40'hAB_CDEF_0123}, // R2 upper bits ignored
      '{va:64'h0000_0000_0001_9004, hit:1'b0, pfn:40'h00_0000_0042}, // R8 conflict slot 9
      '{va:64'h0000_1234_5678_9ABC, hit:1'b0, pfn:40'hFF_FFFF_FFFF}, // R8 old page evicted
      '{va:64'h0000_0000_0001_0000, hit:1'b0, pfn:40'h12_3456_789A}, // R4 slot 0
      '{va:64'h0000_0000_0001_0FFF, hit:1'b1, pfn:40'h12_3456_789A}, // R6 refilled page hits
      '{va:64'h0000_1234_5678_9001, hit:1'b1, pfn:40'hFF_FFFF_FFFF}, // R6 slot 9 kept
      '{va:64'h0000_7FFF_FFFF_FFFF, hit:1'b0, pfn:40'h55_AAAA_5555}, // R4 slot 15
      '{va:64'h0000_7FFF_FFFF_F000, hit:1'b1, pfn:40'h55_AAAA_5555}  // R3 slot 15 hit
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [63:0] req_vaddr = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic [51:0] rsp_paddr;
   logic        walk_valid;
   logic        walk_ready = 1'b0;
   logic [35:0] walk_vpn;
   logic        refill_valid = 1'b0;
   logic [39:0] refill_pfn = '0;

   int n_total = 0;
   int n_bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tlb_xlate u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
      .walk_valid(walk_valid), .walk_ready(walk_ready), .walk_vpn(walk_vpn),
      .refill_valid(refill_valid), .refill_pfn(refill_pfn)
   );

   task automatic check(input logic ok, input string rq, input logic [63:0] act,
                        input logic [63:0] exp);
      n_total++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic translate(input logic [63:0] va, input logic hit,
                            input logic [39:0] pfn, input string rq);
      logic [63:0] exp_pa;
      exp_pa = {12'h0, pfn, va[11:0]};
      @(negedge clk);
      check(req_ready == 1'b1, {rq, " R5 ready before request"}, 64'(req_ready), 64'd1);
      req_valid = 1'b1;
      req_vaddr = va;
      @(negedge clk);
      req_valid = 1'b0;
      if (hit) begin
         check(rsp_valid == 1'b1, {rq, " R3 hit answers next cycle"}, 64'(rsp_valid), 64'd1);
         check(walk_valid == 1'b0, {rq, " R3 hit needs no walk"}, 64'(walk_valid), 64'd0);
      end else begin
         check(walk_valid == 1'b1, {rq, " R4 miss raises walk"}, 64'(walk_valid), 64'd1);
         check(walk_vpn == va[47:12], {rq, " R4 walk page"}, 64'(walk_vpn), 64'(va[47:12]));
         check(rsp_valid == 1'b0, {rq, " R4 no early answer"}, 64'(rsp_valid), 64'd0);
         check(req_ready == 1'b0, {rq, " R5 busy during walk"}, 64'(req_ready), 64'd0);
         @(negedge clk);
         check(walk_valid == 1'b1 && walk_vpn == va[47:12], {rq, " R10 walk held"},
               64'(walk_vpn), 64'(va[47:12]));
         walk_ready = 1'b1;
         @(negedge clk);
         walk_ready = 1'b0;
         check(walk_valid == 1'b0, {rq, " R10 walk drops after accept"}, 64'(walk_valid), 64'd0);
         check(req_ready == 1'b0, {rq, " R5 busy awaiting refill"}, 64'(req_ready), 64'd0);
         refill_valid = 1'b1;
         refill_pfn   = pfn;
         @(negedge clk);
         refill_valid = 1'b0;
         refill_pfn   = '0;
         check(rsp_valid == 1'b1, {rq, " R6 answer after refill"}, 64'(rsp_valid), 64'd1);
      end
      check(64'(rsp_paddr) == exp_pa, {rq, " R2 physical address"}, 64'(rsp_paddr), exp_pa);
      @(negedge clk);
      check(rsp_valid == 1'b1 && 64'(rsp_paddr) == exp_pa, {rq, " R9 answer held"},
            64'(rsp_paddr), exp_pa);
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      check(rsp_valid == 1'b0 && req_ready == 1'b1, {rq, " R9 ready returns"},
            64'({rsp_valid, req_ready}), 64'b01);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL R5 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state at the ports
      check(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
      check(rsp_valid == 1'b0, "R1 no answer after reset", 64'(rsp_valid), 64'd0);
      check(walk_valid == 1'b0, "R1 no walk after reset", 64'(walk_valid), 64'd0);

      for (int i = 0; i < NV; i++) begin
         translate(VECS[i].va, VECS[i].hit, VECS[i].pfn, $sformatf("vec%0d", i));
      end

      // R7 stray refill while idle must not touch slot 15
      @(negedge clk);
      refill_valid = 1'b1;
      refill_pfn   = 40'h0F_0F0F_0F0F;
      @(negedge clk);
      refill_valid = 1'b0;
      check(rsp_valid == 1'b0, "R7 stray refill gives no answer", 64'(rsp_valid), 64'd0);
      check(req_ready == 1'b1, "R7 stray refill keeps idle", 64'(req_ready), 64'd1);
      translate(VECS[9].va, 1'b1, VECS[9].pfn, "R7 slot kept");

      // R5 second request offered during a walk is not taken
      @(negedge clk);
      req_valid = 1'b1;
      req_vaddr = 64'h0000_0000_0002_2345;
      @(negedge clk);
      req_vaddr = 64'h0000_0000_0003_3777;
      check(req_ready == 1'b0, "R5 not ready while walking", 64'(req_ready), 64'd0);
      check(walk_vpn == 36'h0_0000_0022, "R5 walk keeps first page", 64'(walk_vpn), 64'h22);
      walk_ready = 1'b1;
      @(negedge clk);
      walk_ready = 1'b0;
      check(walk_valid == 1'b0 && req_ready == 1'b0, "R5 no second walk",
            64'({walk_valid, req_ready}), 64'd0);
      refill_valid = 1'b1;
      refill_pfn   = 40'h33_4455_6677;
      @(negedge clk);
      refill_valid = 1'b0;
      req_valid    = 1'b0;
      check(64'(rsp_paddr) == 64'h3_3445_5667_7345, "R5 answer for first request",
            64'(rsp_paddr), 64'h3_3445_5667_7345);
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      translate(64'h0000_0000_0003_3777, 1'b0, 40'h01_0203_0405, "R5 second later misses");

      // R1 reset clears slots that were valid
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      translate(VECS[8].va, 1'b0, 40'h77_6655_4433, "R1 cleared by reset");

      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
   end
endmodule